// File: doc/BRIEF.md
# I2C Slave Byte Front End

This block watches the two wires of an I2C bus, samples them with the system clock, and turns bus activity into byte-level events for a command controller placed after it. It sees start, repeated-start and stop conditions. It checks the slave address of each transaction against a fixed 4-bit device nibble and two strap inputs. It collects write data MSB first and serialises read data supplied by the controller. On SDA it only pulls the line low or lets it go, as an open-drain driver does.

The controller gets single-cycle strobes for start, stop, address match (with the direction bit), received byte and "next transmit byte wanted". For each written data byte, the controller decides whether to acknowledge it through `ack_i`. The address byte is always acknowledged when it matches. The block has no clock stretching, so the system clock must be fast enough that `SYNC_STAGES + 2` cycles fit well inside a quarter of an SCL period.

Top module: `i2c_slave_frontend`

## Requirements
- R1: `start_o` pulses for one cycle when SDA falls while SCL is high. This includes a repeated start in the middle of a transaction, which restarts address reception.
- R2: `stop_o` pulses for one cycle when SDA rises while SCL is high. Any transfer in progress, even a partial address, is abandoned, and SDA is released.
- R3: An address byte matches when bits 7:4 equal `DEV_NIBBLE` (default 4'b1010) and bits 3:2 equal `strap_i[1:0]`. Bit 1 is ignored and bit 0 is the direction (1 = read). On a match, `addr_match_o` pulses after the eighth SCL rising edge with `addr_rw_o` equal to bit 0, and SDA is held low through the ninth clock.
- R4: A non-matching address gets no acknowledge. No address, byte or transmit-request strobe follows until the next start or stop.
- R5: In a write transaction, each data byte is shifted in MSB first and presented on `rx_byte_o` with a one-cycle `rx_valid_o` after its eighth rising edge.
- R6: The acknowledge for a written data byte is taken from `ack_i` (1 = ACK, drive low; 0 = NACK, release) at the SCL fall after the eighth bit. After a NACK, all following bytes are ignored until a start or stop.
- R7: In a read transaction, `tx_req_o` pulses at the address match and at each master ACK. `tx_byte_i` is captured at the SCL fall that ends the ninth clock and shifted out MSB first. SDA changes only while SCL is low.
- R8: A master NACK on a read byte ends transmission. SDA stays released, no `tx_req_o` follows, and further clocks read back all ones until a start or stop.
- R9: While `rst_n` is low, all strobes, `addr_rw_o`, `rx_byte_o` and `sda_drive_low_o` are zero.
- R10: `sda_drive_low_o` never changes while the synchronised SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| strap_i | input | 2 | Address strap pins, compared with address bits 3:2 |
| ack_i | input | 1 | Acknowledge decision for the current written byte (1 = ACK) |
| tx_byte_i | input | 8 | Next byte to transmit in a read |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| start_o | output | 1 | Start or repeated start strobe |
| stop_o | output | 1 | Stop strobe |
| addr_match_o | output | 1 | Address matched strobe |
| addr_rw_o | output | 1 | Direction of the last matched address (1 = read) |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_byte_o | output | 8 | Last received data byte |
| tx_req_o | output | 1 | Request for the next transmit byte |

## Verification
The bench uses the default parameters: a two-flop synchroniser and device nibble 4'b1010. The strap inputs are set first to 2'b10 and then to 2'b01, so each strap bit is compared against both a 0 and a 1. The bit-1 don't-care position is sent as both values. With these settings the bench covers matching and non-matching addresses, a write that turns into a read through a repeated start, controller NACKs and master NACKs, and a stop arriving halfway through an address byte.

// File: rtl/i2cfe_pkg.sv
// Shared types and constants for the I2C slave byte front end.
package i2cfe_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,   // bus free or not addressed
        ST_ADDR,   // collecting the address byte
        ST_RX,     // collecting a written data byte
        ST_SACK,   // slave acknowledge bit (address or data)
        ST_TX,     // shifting a read byte out
        ST_MACK,   // master acknowledge bit after a read byte
        ST_HOLD    // ignoring the bus until start or stop
    } fe_state_t;
endpackage

// File: rtl/i2cfe_sync.sv
// Synchroniser for one bus line with edge flags.
// Assumes STAGES >= 2. The idle level of the line is high, so the reset value is 1.
module i2cfe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Shift the raw line through the chain and remember the previous settled value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            last  <= chain[STAGES-1];
        end
    end

    assign line_o = chain[STAGES-1];
    assign rise_o = line_o & ~last;
    assign fall_o = ~line_o & last;
endmodule

// File: rtl/i2cfe_cond.sv
// Bus condition decoder: start and stop from the synchronised levels and edges.
// Assumes the SCL and SDA flags come from identical synchroniser chains.
module i2cfe_cond (
    input  logic scl_level_i,
    input  logic sda_rise_i,
    input  logic sda_fall_i,
    output logic start_o,
    output logic stop_o
);
    // A data edge while the clock is high is a bus condition, never data.
    always_comb begin
        start_o = scl_level_i & sda_fall_i;
        stop_o  = scl_level_i & sda_rise_i;
    end
endmodule

// File: rtl/i2cfe_shifter.sv
// Byte shift register with bit counter, shared by receive and transmit.
// Priority: clear > load > shift. Shifting moves MSB first.
module i2cfe_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] data_o,
    output logic [WIDTH-1:0] next_o,
    output logic             last_o,
    output logic             full_o
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [CNT_W-1:0] count;

    // Update the register and the count of bits taken since the last clear or load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            count  <= '0;
        end else if (clr_i) begin
            count  <= '0;
        end else if (load_i) begin
            data_o <= load_val_i;
            count  <= '0;
        end else if (shift_i) begin
            data_o <= next_o;
            count  <= count + 1'b1;
        end
    end

    assign next_o = {data_o[WIDTH-2:0], bit_i};
    assign last_o = (count == CNT_W'(WIDTH - 1));
    assign full_o = (count == CNT_W'(WIDTH));
endmodule

// File: rtl/i2c_slave_frontend.sv
// I2C slave byte front end: bus conditions, address match, byte receive,
// acknowledge driving and byte transmit, with single-cycle event strobes.
// Assumes the system clock is much faster than SCL (no clock stretching).
module i2c_slave_frontend
    import i2cfe_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_NIBBLE  = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    input  logic              ack_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              sda_drive_low_o,
    output logic              start_o,
    output logic              stop_o,
    output logic              addr_match_o,
    output logic              addr_rw_o,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              tx_req_o
);
    localparam int LINES = 2;   // index 0 = SCL, index 1 = SDA

    logic [LINES-1:0] raw_lines, lvl, rise, fall;
    logic scl_s, sda_s, scl_rise, scl_fall;
    logic start_det, stop_det;
    logic sh_clr, sh_load, sh_shift, sh_last, sh_full;
    logic [BYTE_W-1:0] sh_data, sh_next;
    logic addr_hit;
    fe_state_t state;
    logic ack_phase, addr_phase, nack_q, mack_ok;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_sync
        i2cfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    assign scl_s    = lvl[0];
    assign sda_s    = lvl[1];
    assign scl_rise = rise[0];
    assign scl_fall = fall[0];

    i2cfe_cond u_cond (
        .scl_level_i (scl_s),
        .sda_rise_i  (rise[1]),
        .sda_fall_i  (fall[1]),
        .start_o     (start_det),
        .stop_o      (stop_det)
    );

    // Shifter control: shift on data clocks, reload for each read byte, clear per byte.
    always_comb begin
        sh_shift = scl_rise && (state == ST_ADDR || state == ST_RX || state == ST_TX);
        sh_load  = scl_fall && ((state == ST_SACK && ack_phase && !nack_q && addr_rw_o) ||
                                (state == ST_MACK && mack_ok));
        sh_clr   = start_det || (scl_fall && state == ST_SACK && ack_phase && !sh_load);
    end

    i2cfe_shifter #(.WIDTH(BYTE_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (sh_clr),
        .load_i     (sh_load),
        .shift_i    (sh_shift),
        .bit_i      (sda_s),
        .load_val_i (tx_byte_i),
        .data_o     (sh_data),
        .next_o     (sh_next),
        .last_o     (sh_last),
        .full_o     (sh_full)
    );

    // Address compare on the completed byte; bit 1 is ignored, bit 0 is direction.
    assign addr_hit = (sh_next[7:4] == DEV_NIBBLE) && (sh_next[3:2] == strap_i);

    // Transaction sequencer: strobes, acknowledge and transmit drive of SDA.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_IDLE;
            start_o         <= 1'b0;
            stop_o          <= 1'b0;
            addr_match_o    <= 1'b0;
            addr_rw_o       <= 1'b0;
            rx_valid_o      <= 1'b0;
            rx_byte_o       <= '0;
            tx_req_o        <= 1'b0;
            sda_drive_low_o <= 1'b0;
            ack_phase       <= 1'b0;
            addr_phase      <= 1'b0;
            nack_q          <= 1'b0;
            mack_ok         <= 1'b0;
        end else begin
            start_o      <= 1'b0;
            stop_o       <= 1'b0;
            addr_match_o <= 1'b0;
            rx_valid_o   <= 1'b0;
            tx_req_o     <= 1'b0;
            if (start_det) begin
                state           <= ST_ADDR;
                start_o         <= 1'b1;
                sda_drive_low_o <= 1'b0;
            end else if (stop_det) begin
                state           <= ST_IDLE;
                stop_o          <= 1'b1;
                sda_drive_low_o <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise && sh_last) begin
                            if (addr_hit) begin
                                addr_match_o <= 1'b1;
                                addr_rw_o    <= sh_next[0];
                                tx_req_o     <= sh_next[0];
                                addr_phase   <= 1'b1;
                                ack_phase    <= 1'b0;
                                state        <= ST_SACK;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise && sh_last) begin
                            rx_valid_o <= 1'b1;
                            rx_byte_o  <= sh_next;
                            addr_phase <= 1'b0;
                            ack_phase  <= 1'b0;
                            state      <= ST_SACK;
                        end
                    end
                    ST_SACK: begin
                        if (scl_fall) begin
                            if (!ack_phase) begin
                                ack_phase       <= 1'b1;
                                sda_drive_low_o <= addr_phase | ack_i;
                                nack_q          <= ~(addr_phase | ack_i);
                            end else if (nack_q) begin
                                sda_drive_low_o <= 1'b0;
                                state           <= ST_HOLD;
                            end else if (addr_rw_o) begin
                                sda_drive_low_o <= ~tx_byte_i[BYTE_W-1];
                                state           <= ST_TX;
                            end else begin
                                sda_drive_low_o <= 1'b0;
                                state           <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (sh_full) begin
                                sda_drive_low_o <= 1'b0;
                                state           <= ST_MACK;
                            end else begin
                                sda_drive_low_o <= ~sh_data[BYTE_W-1];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok  <= ~sda_s;
                            tx_req_o <= ~sda_s;
                        end
                        if (scl_fall) begin
                            if (mack_ok) begin
                                sda_drive_low_o <= ~tx_byte_i[BYTE_W-1];
                                state           <= ST_TX;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cfe_checker.sv
// Protocol checker for the I2C slave byte front end, bound to the top module.
module i2cfe_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_drive_low_o,
    input logic start_o,
    input logic stop_o,
    input logic addr_match_o,
    input logic addr_rw_o,
    input logic rx_valid_o,
    input logic tx_req_o
);
    assert_start_stop_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    assert_stop_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    assert_addr_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !addr_match_o);

    assert_rx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_txreq_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> addr_rw_o);

    assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low_o) |-> !scl_s);
endmodule

bind i2c_slave_frontend i2cfe_checker u_i2cfe_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_s           (scl_s),
    .sda_drive_low_o (sda_drive_low_o),
    .start_o         (start_o),
    .stop_o          (stop_o),
    .addr_match_o    (addr_match_o),
    .addr_rw_o       (addr_rw_o),
    .rx_valid_o      (rx_valid_o),
    .tx_req_o        (tx_req_o)
);

// File: tb/test_i2c_slave_frontend.sv
// Scoreboard bench: the bus driver queues expected events, a monitor compares strobes.
module test_i2c_slave_frontend;
    localparam int Q = 8;   // system clocks per quarter SCL period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       ack_in = 1'b1;
    logic [7:0] tx_byte = 8'h00;

    logic       sda_drive_low, start_s, stop_s, addr_s, rw_s, rx_s, txreq_s;
    logic [7:0] rx_byte;
    logic       sda_line;

    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;
    logic [15:0] exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    assign sda_line = sda_m & ~sda_drive_low;

    i2c_slave_frontend i_i2c_slave_frontend (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl_m),
        .sda_i           (sda_line),
        .strap_i         (strap),
        .ack_i           (ack_in),
        .tx_byte_i       (tx_byte),
        .sda_drive_low_o (sda_drive_low),
        .start_o         (start_s),
        .stop_o          (stop_s),
        .addr_match_o    (addr_s),
        .addr_rw_o       (rw_s),
        .rx_valid_o      (rx_s),
        .rx_byte_o       (rx_byte),
        .tx_req_o        (txreq_s)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // kind: 1 start, 2 stop, 3 address (data = rw), 4 rx byte, 5 tx request
    task automatic expect_ev(input int req, input int kind, input logic [7:0] d);
        exp_q.push_back({4'(req), 4'(kind), d});
    endtask

    task automatic match_ev(input int kind, input logic [7:0] d);
        logic [15:0] it;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R%0d unexpected event: actual kind %0d data %0h expected none",
                     (kind == 1) ? 1 : (kind == 2) ? 2 : (kind == 3) ? 3 : (kind == 4) ? 5 : 7,
                     kind, d);
        end else begin
            it = exp_q.pop_front();
            if (it[11:8] != 4'(kind) || it[7:0] != d) begin
                fails++;
                $display("FAIL R%0d event: actual kind %0d data %0h expected kind %0d data %0h",
                         it[15:12], kind, d, it[11:8], it[7:0]);
            end
        end
    endtask

    // Monitor: strobes compared in fixed order start, stop, address, rx, tx request.
    always @(negedge clk) begin
        if (rst_n) begin
            if (start_s) match_ev(1, 8'h00);
            if (stop_s)  match_ev(2, 8'h00);
            if (addr_s)  match_ev(3, {7'b0, rw_s});
            if (rx_s)    match_ev(4, rx_byte);
            if (txreq_s) match_ev(5, 8'h00);
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(Q);
        s = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic mack, input logic [7:0] next_tx,
                             output logic [7:0] d);
        logic s;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, s);
            d = {d[6:0], s};
        end
        tx_byte = next_tx;
        clock_bit(~mack, s);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        logic       ack;
        logic [7:0] d;

        // R9: reset state
        tick(4);
        check({sda_drive_low, start_s, stop_s, addr_s, rw_s, rx_s, txreq_s, rx_byte} == '0,
              "R9", "outputs in reset",
              int'({sda_drive_low, start_s, stop_s, addr_s, rw_s, rx_s, txreq_s, rx_byte}), 0);
        rst_n = 1'b1;
        tick(6);

        // Write with strap 10, don't-care bit 1: R3, R5, R6, R2
        expect_ev(1, 1, 0); bus_start();
        expect_ev(3, 3, 0); write_byte(8'hAA, ack);
        check(ack == 1'b1, "R3", "address ACK", int'(ack), 1);
        ack_in = 1'b1;
        expect_ev(5, 4, 8'h5A); write_byte(8'h5A, ack);
        check(ack == 1'b1, "R6", "data ACK from ack_i", int'(ack), 1);
        ack_in = 1'b0;
        expect_ev(5, 4, 8'hC3); write_byte(8'hC3, ack);
        check(ack == 1'b0, "R6", "data NACK from ack_i", int'(ack), 0);
        ack_in = 1'b1;
        write_byte(8'h11, ack);   // R6: ignored after NACK, no event expected
        check(ack == 1'b0, "R6", "byte after NACK not acknowledged", int'(ack), 0);
        expect_ev(2, 2, 0); bus_stop();
        check(sda_drive_low == 1'b0, "R2", "SDA released after stop", int'(sda_drive_low), 0);

        // R4: strap mismatch, then nibble mismatch
        expect_ev(1, 1, 0); bus_start();
        write_byte(8'hA2, ack);
        check(ack == 1'b0, "R4", "strap mismatch not acknowledged", int'(ack), 0);
        write_byte(8'h5A, ack);
        check(ack == 1'b0, "R4", "data after mismatch ignored", int'(ack), 0);
        expect_ev(2, 2, 0); bus_stop();
        expect_ev(1, 1, 0); bus_start();
        write_byte(8'hBA, ack);
        check(ack == 1'b0, "R4", "nibble mismatch not acknowledged", int'(ack), 0);
        expect_ev(2, 2, 0); bus_stop();

        // Write then repeated start into read, strap 01: R1, R3, R7, R8
        strap = 2'b01;
        expect_ev(1, 1, 0); bus_start();
        expect_ev(3, 3, 0); write_byte(8'hA4, ack);
        check(ack == 1'b1, "R3", "address ACK strap 01", int'(ack), 1);
        expect_ev(5, 4, 8'h84); write_byte(8'h84, ack);
        check(ack == 1'b1, "R5", "command byte ACK", int'(ack), 1);
        expect_ev(1, 1, 0); bus_start();   // R1 repeated start
        tx_byte = 8'h96;
        expect_ev(3, 3, 1); expect_ev(7, 5, 0);
        write_byte(8'hA5, ack);
        check(ack == 1'b1, "R3", "read address ACK", int'(ack), 1);
        expect_ev(7, 5, 0); read_byte(1'b1, 8'h3C, d);
        check(d == 8'h96, "R7", "read byte 0", int'(d), 'h96);
        expect_ev(7, 5, 0); read_byte(1'b1, 8'hF0, d);
        check(d == 8'h3C, "R7", "read byte 1", int'(d), 'h3C);
        read_byte(1'b0, 8'h00, d);
        check(d == 8'hF0, "R7", "read byte 2", int'(d), 'hF0);
        read_byte(1'b1, 8'h00, d);
        check(d == 8'hFF, "R8", "released after master NACK", int'(d), 'hFF);
        expect_ev(2, 2, 0); bus_stop();

        // R2: stop halfway through an address, then a fresh transaction
        expect_ev(1, 1, 0); bus_start();
        clock_bit(1'b1, ack); clock_bit(1'b0, ack); clock_bit(1'b1, ack); clock_bit(1'b0, ack);
        expect_ev(2, 2, 0); bus_stop();
        expect_ev(1, 1, 0); bus_start();
        expect_ev(3, 3, 0); write_byte(8'hA6, ack);
        check(ack == 1'b1, "R3", "don't-care bit set still matches", int'(ack), 1);
        expect_ev(2, 2, 0); bus_stop();

        tick(20);
        while (exp_q.size() != 0) begin
            logic [15:0] it;
            it = exp_q.pop_front();
            checks++; fails++;
            $display("FAIL R%0d missing event: actual none expected kind %0d data %0h",
                     it[15:12], it[11:8], it[7:0]);
        end
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R1-watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule